// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out the atomic store-class operations of a 64-bit register machine against a plain single-port memory. A caller pulses `start_i` together with the operation code, the access size, the base register, a signed 16-bit displacement, the source register and the comparand register (register zero). The unit reads the target location under a lock, forms the new value, writes it back and reports which architectural registers must be updated with the value that memory held before the change.

The memory side uses one request/ready handshake. A transfer completes on a clock edge where `mem_req_o` and `mem_ready_i` are both high. `mem_we_o` tells writes from reads, and `mem_dword_o` tells 8-byte from 4-byte accesses. `mem_lock_o` is raised with the read request and held until the write completes, so that an outside arbiter can keep other masters away. After a failed compare there is no write, and the lock drops once the read is done.

Requests that are not legal are refused in one cycle and never touch memory. A request is not legal when it has an unknown operation code or a size that cannot be atomic.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `mem_req_o`, `mem_lock_o`, `done_o` and `err_o` are low.
- R2: The read and the write of one operation both go to `dst_i + sign_extend(off_i)`, computed modulo 2^64. Exactly one read precedes at most one write.
- R3: The value written is old+src for code 0x00 or 0x01, old|src for 0x40 or 0x41, old&src for 0x50 or 0x51, and old^src for 0xa0 or 0xa1. Addition wraps.
- R4: When bit 0 of the operation code is set on a simple operation (0x01, 0x41, 0x51, 0xa1), `src_wb_valid_o` is high in the done cycle and `src_wb_data_o` holds the old memory value. With bit 0 clear, neither write-back valid is raised.
- R5: Code 0xe1 (exchange) writes the source register to memory and returns the old value through the source write-back.
- R6: Code 0xf1 (compare-and-exchange) writes the source register only when the old value equals `r0_i`. In both cases it raises `r0_wb_valid_o` with the old value and not the source write-back.
- R7: Size code 2'b00 (4 bytes) uses only bits 31:0 of memory and operands. `mem_wdata_o[63:32]` is zero, and returned values are zero-extended. Size code 2'b11 (8 bytes) uses all 64 bits.
- R8: Size codes 2'b01 and 2'b10, any operation code outside the listed ones, or any nonzero bit in `imm_i[31:8]` raise `err_o` for one cycle in the cycle after the start edge. There is then no memory request and no `done_o`.
- R9: `mem_lock_o` is high whenever `mem_req_o` is high, and it stays high between the read and the write. It is low in the done cycle.
- R10: While a request waits for `mem_ready_i`, the request, direction, address and write data stay stable.
- R11: A start pulse that arrives while an operation is in progress, including its done cycle, is ignored.
- R12: `done_o` is a single-cycle pulse, and write-back valids are raised only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled in the idle state |
| size_i | input | 2 | Access size code (00 = 4 bytes, 11 = 8 bytes) |
| imm_i | input | 32 | Operation code field |
| dst_i | input | 64 | Base address register |
| off_i | input | 16 | Signed displacement |
| src_i | input | 64 | Source register value |
| r0_i | input | 64 | Comparand register value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_lock_o | output | 1 | Hold off other masters |
| mem_dword_o | output | 1 | Access is 8 bytes wide |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with ready on a read |
| mem_ready_i | input | 1 | Memory accepts or completes the request |
| done_o | output | 1 | Operation finished |
| err_o | output | 1 | Request refused |
| src_wb_valid_o | output | 1 | Source register must take src_wb_data_o |
| src_wb_data_o | output | 64 | Old memory value for the source register |
| r0_wb_valid_o | output | 1 | Register zero must take r0_wb_data_o |
| r0_wb_data_o | output | 64 | Old memory value for register zero |

## Verification
Two things can fall in the same cycle. One is a fresh start request arriving in the done cycle of the previous operation. The other is memory readiness arriving in the very first cycle of a request. The bench provokes the first by holding `start_i` high through an entire operation and one cycle past `done_o`. It judges the result by the number of reads and writes seen at the memory and by the final memory word, both of which must show a single operation. The second case comes from random and always-ready cycles of `mem_ready_i`; the same memory contents and write-back values are expected whatever the number of wait cycles.

// File: rtl/atom_pkg.sv
package atom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_READ,
    ST_COMPUTE,
    ST_WRITE,
    ST_WAIT_WRITE,
    ST_DONE
  } atom_state_e;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_XCHG,
    OP_CMPXCHG
  } atom_op_e;

  typedef struct packed {
    atom_op_e op;
    logic     fetch;
    logic     dword;
  } atom_cmd_t;

  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b11;

  localparam logic [7:0] CODE_ADD     = 8'h00;
  localparam logic [7:0] CODE_OR      = 8'h40;
  localparam logic [7:0] CODE_AND     = 8'h50;
  localparam logic [7:0] CODE_XOR     = 8'ha0;
  localparam logic [7:0] CODE_XCHG    = 8'he1;
  localparam logic [7:0] CODE_CMPXCHG = 8'hf1;

endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       size_i,
  output logic             legal_o,
  output atom_cmd_t        cmd_o
);

  localparam int CODE_W = 8;

  logic op_known;
  logic upper_clear;
  logic size_ok;

  assign upper_clear = (imm_i[IMM_W-1:CODE_W] == '0);
  assign size_ok     = (size_i == SZ_WORD) || (size_i == SZ_DWORD);

  always_comb begin
    op_known    = 1'b1;
    cmd_o.op    = OP_ADD;
    cmd_o.fetch = imm_i[0];
    cmd_o.dword = (size_i == SZ_DWORD);
    case (imm_i[CODE_W-1:0])
      CODE_ADD, CODE_ADD | 8'h01: cmd_o.op = OP_ADD;
      CODE_OR,  CODE_OR  | 8'h01: cmd_o.op = OP_OR;
      CODE_AND, CODE_AND | 8'h01: cmd_o.op = OP_AND;
      CODE_XOR, CODE_XOR | 8'h01: cmd_o.op = OP_XOR;
      CODE_XCHG:                  cmd_o.op = OP_XCHG;
      CODE_CMPXCHG:               cmd_o.op = OP_CMPXCHG;
      default:                    op_known = 1'b0;
    endcase
  end

  assign legal_o = op_known && upper_clear && size_ok;

endmodule

// File: rtl/atom_agen.sv
module atom_agen #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  addr_o
);

  localparam int EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_ext;

  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign addr_o  = base_i + off_ext;

endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  atom_cmd_t        cmd_i,
  input  logic [XLEN-1:0]  old_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  r0_i,
  output logic [XLEN-1:0]  new_o,
  output logic             wr_o,
  output logic             src_wb_o,
  output logic             r0_wb_o
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] old_m;
  logic [XLEN-1:0] src_m;
  logic [XLEN-1:0] r0_m;
  logic [XLEN-1:0] raw;

  assign mask  = cmd_i.dword ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign old_m = old_i & mask;
  assign src_m = src_i & mask;
  assign r0_m  = r0_i & mask;

  always_comb begin
    raw = src_m;
    case (cmd_i.op)
      OP_ADD:  raw = old_m + src_m;
      OP_OR:   raw = old_m | src_m;
      OP_AND:  raw = old_m & src_m;
      OP_XOR:  raw = old_m ^ src_m;
      default: raw = src_m;
    endcase
  end

  assign new_o    = raw & mask;
  assign wr_o     = (cmd_i.op != OP_CMPXCHG) || (old_m == r0_m);
  assign r0_wb_o  = (cmd_i.op == OP_CMPXCHG);
  assign src_wb_o = (cmd_i.op == OP_XCHG) ||
                    (cmd_i.fetch && (cmd_i.op != OP_CMPXCHG));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       size_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  dst_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  r0_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             mem_lock_o,
  output logic             mem_dword_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             done_o,
  output logic             err_o,
  output logic             src_wb_valid_o,
  output logic [XLEN-1:0]  src_wb_data_o,
  output logic             r0_wb_valid_o,
  output logic [XLEN-1:0]  r0_wb_data_o
);

  localparam int HALF = XLEN / 2;

  atom_state_e     state_q, state_d;
  atom_cmd_t       cmd_dec, cmd_q;
  logic            legal;
  logic [XLEN-1:0] addr_calc, addr_q;
  logic [XLEN-1:0] src_q, r0_q, old_q, wdata_q;
  logic [XLEN-1:0] alu_new;
  logic            alu_wr, alu_src_wb, alu_r0_wb;
  logic            src_v_q, r0_v_q, err_q;
  logic [XLEN-1:0] rdata_sized;

  atom_decode #(.IMM_W(IMM_W)) i_decode (
    .imm_i   (imm_i),
    .size_i  (size_i),
    .legal_o (legal),
    .cmd_o   (cmd_dec)
  );

  atom_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) i_agen (
    .base_i (dst_i),
    .off_i  (off_i),
    .addr_o (addr_calc)
  );

  atom_alu #(.XLEN(XLEN)) i_alu (
    .cmd_i    (cmd_q),
    .old_i    (old_q),
    .src_i    (src_q),
    .r0_i     (r0_q),
    .new_o    (alu_new),
    .wr_o     (alu_wr),
    .src_wb_o (alu_src_wb),
    .r0_wb_o  (alu_r0_wb)
  );

  assign rdata_sized = cmd_q.dword ? mem_rdata_i
                                   : {{HALF{1'b0}}, mem_rdata_i[HALF-1:0]};

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start_i && legal) state_d = ST_READ;
      ST_READ:       state_d = mem_ready_i ? ST_COMPUTE : ST_WAIT_READ;
      ST_WAIT_READ:  if (mem_ready_i) state_d = ST_COMPUTE;
      ST_COMPUTE:    state_d = alu_wr ? ST_WRITE : ST_DONE;
      ST_WRITE:      state_d = mem_ready_i ? ST_DONE : ST_WAIT_WRITE;
      ST_WAIT_WRITE: if (mem_ready_i) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      wdata_q <= '0;
      src_v_q <= 1'b0;
      r0_v_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_IDLE) && start_i && !legal;
      case (state_q)
        ST_IDLE: begin
          src_v_q <= 1'b0;
          r0_v_q  <= 1'b0;
          if (start_i && legal) begin
            cmd_q  <= cmd_dec;
            addr_q <= addr_calc;
            src_q  <= src_i;
            r0_q   <= r0_i;
          end
        end
        ST_READ, ST_WAIT_READ: begin
          if (mem_ready_i) old_q <= rdata_sized;
        end
        ST_COMPUTE: begin
          wdata_q <= alu_new;
          src_v_q <= alu_src_wb;
          r0_v_q  <= alu_r0_wb;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WAIT_READ) ||
                       (state_q == ST_WRITE) || (state_q == ST_WAIT_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE) || (state_q == ST_WAIT_WRITE);
  assign mem_lock_o  = mem_req_o || (state_q == ST_COMPUTE);
  assign mem_dword_o = cmd_q.dword;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  assign done_o         = (state_q == ST_DONE);
  assign err_o          = err_q;
  assign src_wb_valid_o = done_o && src_v_q;
  assign r0_wb_valid_o  = done_o && r0_v_q;
  assign src_wb_data_o  = old_q;
  assign r0_wb_data_o   = old_q;

endmodule

// File: rtl/atom_rmw_checker.sv
module atom_rmw_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_lock_o,
  input logic            mem_ready_i,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            done_o,
  input logic            err_o,
  input logic            src_wb_valid_o,
  input logic            r0_wb_valid_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mem_req_o && !mem_lock_o && !done_o && !err_o));

  assert_req_locked_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> mem_lock_o);

  assert_done_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_lock_o);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_err_no_access_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!mem_req_o && !mem_lock_o && !done_o));

  assert_err_follows_start_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(start_i));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_wb_with_done_R12: assert property (@(posedge clk) disable iff (rst)
    (src_wb_valid_o || r0_wb_valid_o) |-> done_o);

  assert_wb_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(src_wb_valid_o && r0_wb_valid_o));

endmodule

bind atomic_rmw_unit atom_rmw_checker #(.XLEN(XLEN)) i_atom_rmw_checker (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_lock_o     (mem_lock_o),
  .mem_ready_i    (mem_ready_i),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_o    (mem_wdata_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .src_wb_valid_o (src_wb_valid_o),
  .r0_wb_valid_o  (r0_wb_valid_o)
);

// File: tb/test_atomic_rmw_unit.sv
`timescale 1ns/1ps
module test_atomic_rmw_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] imm_i = '0;
  logic [63:0] dst_i = '0, src_i = '0, r0_i = '0;
  logic [15:0] off_i = '0;
  logic        mem_req_o, mem_we_o, mem_lock_o, mem_dword_o;
  logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b1;
  logic        done_o, err_o, src_wb_valid_o, r0_wb_valid_o;
  logic [63:0] src_wb_data_o, r0_wb_data_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int ready_mode = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [63:0] rd_addr, wr_addr, wr_data;
  logic [63:0] mem [16];

  always #5 clk = ~clk;

  atomic_rmw_unit i_atomic_rmw_unit (.*);

  assign mem_rdata_i = mem[mem_addr_o[6:3]];

  always @(posedge clk) begin
    cycles++;
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        wr_cnt++;
        wr_addr = mem_addr_o;
        wr_data = mem_wdata_o;
        if (mem_dword_o) mem[mem_addr_o[6:3]] = mem_wdata_o;
        else mem[mem_addr_o[6:3]][31:0] = mem_wdata_o[31:0];
      end else begin
        rd_cnt++;
        rd_addr = mem_addr_o;
      end
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: mem_ready_i = 1'b1;
      1: mem_ready_i = ($urandom % 3) != 0;
      default: mem_ready_i = ($urandom % 4) == 0;
    endcase
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] legal_code(input int k);
    case (k % 10)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h40; 3: return 8'h41;
      4: return 8'h50; 5: return 8'h51; 6: return 8'ha0; 7: return 8'ha1;
      8: return 8'he1; default: return 8'hf1;
    endcase
  endfunction

  function automatic void model(input bit dw, input logic [7:0] code,
      input logic [63:0] old_full, input logic [63:0] s_in, input logic [63:0] r_in,
      output bit wr, output logic [63:0] mem_after,
      output bit sv, output bit rv, output logic [63:0] ret);
    logic [63:0] m, o, s, r, n;
    m = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    o = old_full & m; s = s_in & m; r = r_in & m;
    wr = 1'b1;
    case (code)
      8'h00, 8'h01: n = o + s;
      8'h40, 8'h41: n = o | s;
      8'h50, 8'h51: n = o & s;
      8'ha0, 8'ha1: n = o ^ s;
      8'hf1: begin n = s; wr = (o == r); end
      default: n = s;
    endcase
    n = n & m;
    if (!wr) mem_after = old_full;
    else if (dw) mem_after = n;
    else mem_after = {old_full[63:32], n[31:0]};
    sv  = (code == 8'he1) || (code[0] && code != 8'hf1);
    rv  = (code == 8'hf1);
    ret = o;
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic [7:0] code,
      input logic [63:0] dst, input logic [15:0] off, input logic [63:0] src,
      input logic [63:0] r0, input bit hold);
    logic [63:0] ea, old, exp_mem, exp_ret, got_sd, got_rd;
    bit exp_wr, exp_sv, exp_rv, got, got_sv, got_rv;
    int n;
    ea = dst + {{48{off[15]}}, off};
    old = mem[ea[6:3]];
    model(sz == 2'b11, code, old, src, r0, exp_wr, exp_mem, exp_sv, exp_rv, exp_ret);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    size_i = sz; imm_i = {24'h0, code}; dst_i = dst; off_i = off;
    src_i = src; r0_i = r0; start_i = 1'b1;
    got = 0; n = 0; got_sv = 0; got_rv = 0; got_sd = '0; got_rd = '0;
    while (!got && n < 500) begin
      @(negedge clk);
      n++;
      if (!hold) start_i = 1'b0;
      if (done_o) begin
        got = 1; got_sv = src_wb_valid_o; got_rv = r0_wb_valid_o;
        got_sd = src_wb_data_o; got_rd = r0_wb_data_o;
      end
    end
    check(got, "R12", "done seen", 64'(got), 64'd1);
    @(negedge clk);
    start_i = 1'b0;
    if (hold) begin
      repeat (3) @(negedge clk);
      check(!done_o, "R11", "no second done", 64'(done_o), 64'd0);
    end else begin
      check(!done_o, "R12", "done single cycle", 64'(done_o), 64'd0);
    end
    check(rd_cnt == 1, "R11", "read count", 64'(rd_cnt), 64'd1);
    check(rd_addr == ea, "R2", "read address", rd_addr, ea);
    check(wr_cnt == int'(exp_wr), "R6", "write count", 64'(wr_cnt), 64'(exp_wr));
    if (exp_wr) begin
      check(wr_addr == ea, "R2", "write address", wr_addr, ea);
      if (sz == 2'b00)
        check(wr_data[63:32] == 32'h0, "R7", "word write upper half", wr_data, {32'h0, wr_data[31:0]});
    end
    check(mem[ea[6:3]] == exp_mem, "R3", "memory after op", mem[ea[6:3]], exp_mem);
    check(got_sv == exp_sv, "R4", "src write-back valid", 64'(got_sv), 64'(exp_sv));
    check(got_rv == exp_rv, "R6", "r0 write-back valid", 64'(got_rv), 64'(exp_rv));
    if (exp_sv) check(got_sd == exp_ret, "R5", "src write-back data", got_sd, exp_ret);
    if (exp_rv) check(got_rd == exp_ret, "R7", "r0 write-back data", got_rd, exp_ret);
  endtask

  task automatic run_bad(input logic [1:0] sz, input logic [31:0] imm);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    size_i = sz; imm_i = imm; dst_i = 64'h1040; off_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o, "R8", "error raised", 64'(err_o), 64'd1);
    check(!mem_req_o && !done_o, "R8", "no access on error", 64'({mem_req_o, done_o}), 64'd0);
    @(negedge clk);
    check(!err_o, "R8", "error one cycle", 64'(err_o), 64'd0);
    repeat (2) @(negedge clk);
    check(rd_cnt == 0 && wr_cnt == 0, "R8", "memory untouched", 64'(rd_cnt + wr_cnt), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check(!mem_req_o && !mem_lock_o && !done_o && !err_o, "R1", "reset outputs",
          64'({mem_req_o, mem_lock_o, done_o, err_o}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_req_o && !done_o && !err_o, "R1", "after reset", 64'({mem_req_o, done_o, err_o}), 64'd0);

    // directed: wrap-around add, word masking, negative offset, compare outcomes
    mem[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op(2'b11, 8'h01, 64'h1000, 16'h0000, 64'h1, 64'h0, 0);          // R3 wrap, R4 fetch
    mem[1] = 64'hAAAA_BBBB_FFFF_FFFF;
    run_op(2'b00, 8'h00, 64'h1010, 16'hFFF8, 64'h1234_5678_0000_0002, 64'h0, 0); // R7 word, R2 negative
    mem[2] = 64'h0000_0000_0000_0055;
    run_op(2'b11, 8'hf1, 64'h1010, 16'h0000, 64'h77, 64'h55, 0);        // R6 match
    run_op(2'b11, 8'hf1, 64'h1010, 16'h0000, 64'h99, 64'h55, 0);        // R6 mismatch
    mem[3] = 64'h8000_0001_CAFE_F00D;
    run_op(2'b00, 8'hf1, 64'h1018, 16'h0000, 64'h1, 64'hFFFF_FFFF_CAFE_F00D, 0); // R7 word compare
    run_op(2'b11, 8'he1, 64'h1_0000, 16'h8000, 64'h5A5A, 64'h0, 0);     // R5 exchange, R2 min offset
    ready_mode = 2;
    run_op(2'b11, 8'h50, 64'h1020, 16'h0008, 64'h0F0F, 64'h0, 0);       // R10 slow memory, R4 no fetch
    ready_mode = 0;
    run_op(2'b11, 8'ha1, 64'h1030, 16'h0000, 64'h1111, 64'h0, 1);       // R11 start held through done
    ready_mode = 1;
    run_op(2'b00, 8'h41, 64'h1038, 16'h0000, 64'h00F0_0000_0F00, 64'h0, 1);

    run_bad(2'b01, 32'h0000_0000);   // R8 half-word size
    run_bad(2'b10, 32'h0000_00a0);   // R8 byte size
    run_bad(2'b11, 32'h0000_0002);   // R8 unknown code
    run_bad(2'b00, 32'h0000_0100);   // R8 upper bits set
    run_bad(2'b11, 32'h0000_00e0);   // R8 exchange without fetch bit

    for (int k = 0; k < 80; k++) begin
      logic [7:0]  code;
      logic [63:0] dst, src, r0;
      logic [15:0] off;
      logic [1:0]  sz;
      ready_mode = k % 3;
      code = legal_code($urandom);
      sz   = ($urandom % 2) ? 2'b11 : 2'b00;
      dst  = 64'h1040 + 64'(8 * ($urandom % 4));
      off  = 16'(8 * (int'($urandom % 8) - 4));
      src  = {$urandom, $urandom};
      r0   = {$urandom, $urandom};
      if ($urandom % 2) r0 = mem[(dst + {{48{off[15]}}, off}) >> 3 & 64'hF];
      run_op(sz, code, dst, off, src, r0, ($urandom % 5) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule